// File: doc/BRIEF.md
# Convolution Layer Sequencer with 2x2 Max Pooling

This block runs one convolution layer between a valid/ready input stream and a valid/ready output stream. A command code, taken on a one-cycle start strobe while the block is idle, picks one of two jobs. The load job takes the kernel weights and a bias for every output channel from the input stream and keeps them on-chip. The pass job takes one whole input feature map and then walks a 5x5 window over it. For each output channel it forms the valid convolution outputs in a local buffer. It then reduces every non-overlapping 2x2 group with a maximum and sends the pooled words out.

Weights stay resident across passes, so after one load any number of feature maps can be processed, and only pixels travel per pass. A single-cycle done flag closes each job. The convolution uses one multiply per cycle. With the default sizes (8x8 map, one input channel, two output channels, 16-bit signed data) a pass takes 64 input words, computes 32 convolution outputs, and returns 8 pooled words.

Top module: `conv_layer_seq`

## Requirements
- R1: After reset, in_ready, out_valid and done are all 0, and every stored weight and bias is zero.
- R2: A start with cmd_op = 1 accepts exactly NOUT*(K*K+1) input words. For each output channel in turn (channel 0 first) it takes K*K weights in kernel row-major order (index ky*K+kx), then that channel's bias.
- R3: A start with cmd_op = 2 accepts exactly IMG*IMG pixels in row-major order (index y*IMG+x). It then produces NOUT*(OD/2)^2 output words, where OD = IMG-K+1. All words of channel 0 come before those of channel 1. Within a channel the pooled positions come in row-major order (index py*(OD/2)+px).
- R4: The convolution output at (c, oy, ox) is bias[c] + sum over ky,kx of w[c][ky*K+kx] * x[(oy+ky)*IMG + ox+kx], using signed arithmetic. Only the low DW bits are kept, wrapping in two's complement.
- R5: Each output word is the signed maximum of the four convolution outputs at rows 2py, 2py+1 and columns 2px, 2px+1 of its channel.
- R6: A pass run before any load uses zero weights and zero biases, so every output word is 0.
- R7: A start with cmd_op of 0 or 3 does nothing. A start given while a job is running is ignored, and the running job continues unchanged.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change. A cycle with in_valid low accepts no word.
- R9: done is 1 for exactly one cycle. That cycle is the one after the last word of a job is accepted (the last parameter for a load, the last output word for a pass). In it, in_ready and out_valid are 0.
- R10: Weights and biases stay in place across passes, so successive passes with different maps use the last loaded set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle command strobe, taken only when idle |
| cmd_op | input | 2 | Command code: 1 = load parameters, 2 = process a map |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts an input word |
| in_data | input | DW | Input word (weight, bias or pixel, signed) |
| out_valid | output | 1 | Pooled output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | DW | Pooled output word (signed) |
| done | output | 1 | One-cycle pulse when a job finishes |

## Verification
The hardest situations to reach from the ports are the wrap of an oversized convolution sum (R4) and a 2x2 maximum decided only by sign. Large weights and large alternating-sign pixels drive the sums far outside 16 bits, and the bench predicts their truncated values arithmetically. A stray start strobe is injected in the middle of pixel reception to show that a busy job is not disturbed. Output backpressure on a fixed stall pattern holds words across several cycles. Several passes without a reload, including one before any load, cover the persistence of parameters and the zero-reset weights.

// File: rtl/conv_layer_seq.sv
`timescale 1ns/1ps
module conv_layer_seq #(
  parameter int IMG  = 8,
  parameter int K    = 5,
  parameter int NOUT = 2,
  parameter int DW   = 16,
  parameter int ACCW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [1:0]    cmd_op,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          done
);
  localparam int KK   = K * K;
  localparam int OD   = IMG - K + 1;
  localparam int OD2  = OD * OD;
  localparam int PD   = OD / 2;
  localparam int PD2  = PD * PD;
  localparam int NW   = NOUT * (KK + 1);
  localparam int NPIX = IMG * IMG;
  localparam int NOB  = NOUT * OD2;
  localparam int NPO  = NOUT * PD2;
  localparam int FA   = $clog2(NPIX);
  localparam int WA   = $clog2(NW);
  localparam int OA   = $clog2(NOB);
  localparam int CW   = 16;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_RECV, S_CONV, S_SEND} st_t;
  st_t st;

  logic [CW-1:0] cnt, kx, ky;
  logic signed [ACCW-1:0] acc, acc_n, acc_base;
  logic signed [2*DW-1:0] prod;
  logic signed [DW-1:0] wmem [NW];
  logic signed [DW-1:0] fmap [NPIX];
  logic signed [DW-1:0] obuf [NOB];
  logic signed [DW-1:0] pa, pb, pc, pd, m_top, m_bot;
  int pos, c_ch, c_oy, c_ox, f_addr, w_addr, b_addr;
  int s_ch, s_py, s_px, o_base;
  logic last_tap;

  assign in_ready  = (st == S_LOAD) || (st == S_RECV);
  assign out_valid = (st == S_SEND);
  assign last_tap  = (kx == CW'(K-1)) && (ky == CW'(K-1));

  always_comb begin
    pos    = int'(cnt);
    c_ch   = pos / OD2;
    c_oy   = (pos % OD2) / OD;
    c_ox   = pos % OD;
    f_addr = (c_oy + int'(ky)) * IMG + c_ox + int'(kx);
    w_addr = c_ch * (KK + 1) + int'(ky) * K + int'(kx);
    b_addr = c_ch * (KK + 1) + KK;
    s_ch   = pos / PD2;
    s_py   = (pos % PD2) / PD;
    s_px   = pos % PD;
    o_base = s_ch * OD2 + 2 * s_py * OD + 2 * s_px;
  end

  assign prod     = wmem[WA'(w_addr)] * fmap[FA'(f_addr)];
  assign acc_base = (kx == '0 && ky == '0) ? ACCW'(wmem[WA'(b_addr)]) : acc;
  assign acc_n    = acc_base + ACCW'(prod);

  assign pa    = obuf[OA'(o_base)];
  assign pb    = obuf[OA'(o_base + 1)];
  assign pc    = obuf[OA'(o_base + OD)];
  assign pd    = obuf[OA'(o_base + OD + 1)];
  assign m_top = (pa > pb) ? pa : pb;
  assign m_bot = (pc > pd) ? pc : pd;
  assign out_data = (m_top > m_bot) ? m_top : m_bot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      kx   <= '0;
      ky   <= '0;
      acc  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (cmd_start) begin
          cnt <= '0;
          if (cmd_op == 2'd1) st <= S_LOAD;
          else if (cmd_op == 2'd2) st <= S_RECV;
        end
        S_LOAD: if (in_valid) begin
          if (cnt == CW'(NW-1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_RECV: if (in_valid) begin
          if (cnt == CW'(NPIX-1)) begin
            st  <= S_CONV;
            cnt <= '0;
            kx  <= '0;
            ky  <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_CONV: begin
          acc <= acc_n;
          if (kx == CW'(K-1)) begin
            kx <= '0;
            if (ky == CW'(K-1)) begin
              ky <= '0;
              if (cnt == CW'(NOB-1)) begin
                st  <= S_SEND;
                cnt <= '0;
              end else cnt <= cnt + 1'b1;
            end else ky <= ky + 1'b1;
          end else kx <= kx + 1'b1;
        end
        S_SEND: if (out_ready) begin
          if (cnt == CW'(NPO-1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) wmem[i] <= '0;
    end else if (st == S_LOAD && in_valid) begin
      wmem[WA'(cnt)] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_RECV && in_valid) fmap[FA'(cnt)] <= in_data;
    if (st == S_CONV && last_tap) obuf[OA'(cnt)] <= acc_n[DW-1:0];
  end
endmodule

module conv_layer_seq_chk #(parameter int DW = 16) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          done
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past((in_valid && in_ready) || (out_valid && out_ready))); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready && !out_valid); // R9
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R3
endmodule

bind conv_layer_seq conv_layer_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done)
);

// File: tb/tb_conv_layer_seq.sv
`timescale 1ns/1ps
module tb_conv_layer_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cmd_start, in_valid, in_ready, out_valid, out_ready, done;
  logic [1:0] cmd_op;
  logic [15:0] in_data, out_data;

  conv_layer_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done)
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  int wgt [2][25];
  int bia [2];
  int pix [64];
  int expv [8];

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op);
    @(posedge clk); #1 cmd_start = 1'b1; cmd_op = op;
    @(posedge clk); #1 cmd_start = 1'b0;
  endtask

  task automatic push(input int val, input int gap);
    for (int g = 0; g < gap; g++) @(posedge clk);
    #1 in_valid = 1'b1; in_data = 16'(val);
    for (int t = 0; t < 1000; t++) begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic compute_expected();
    logic signed [15:0] cv [2][4][4];
    longint s;
    int a, b, m1, m2;
    for (int c = 0; c < 2; c++)
      for (int oy = 0; oy < 4; oy++)
        for (int ox = 0; ox < 4; ox++) begin
          s = bia[c];
          for (int ky = 0; ky < 5; ky++)
            for (int kx = 0; kx < 5; kx++)
              s += longint'(wgt[c][ky*5+kx]) * pix[(oy+ky)*8 + ox+kx];
          cv[c][oy][ox] = s[15:0];
        end
    for (int c = 0; c < 2; c++)
      for (int py = 0; py < 2; py++)
        for (int px = 0; px < 2; px++) begin
          a = int'(cv[c][2*py][2*px]);   b = int'(cv[c][2*py][2*px+1]);
          m1 = (a > b) ? a : b;
          a = int'(cv[c][2*py+1][2*px]); b = int'(cv[c][2*py+1][2*px+1]);
          m2 = (a > b) ? a : b;
          expv[c*4 + py*2 + px] = (m1 > m2) ? m1 : m2;
        end
  endtask

  task automatic load_params();
    issue(2'd1);
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 25; k++) push(wgt[c][k], (k % 3 == 0) ? 1 : 0);
      push(bia[c], 0);
    end
    @(negedge clk);
    chk(done === 1'b1, "R9", "done after last parameter", done, 1);
    chk(in_ready === 1'b0, "R2", "no further parameter accepted", in_ready, 0);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done lasts one cycle (load)", done, 0);
  endtask

  task automatic run_pass(input string req, input int stall, input bit poke);
    int got, cyc;
    bit hold;
    logic [15:0] prev;
    compute_expected();
    issue(2'd2);
    for (int i = 0; i < 64; i++) begin
      if (poke && i == 20) begin
        #1 cmd_start = 1'b1; cmd_op = 2'd1;
      end
      push(pix[i], (i % 7 == 3) ? 2 : 0);
      cmd_start = 1'b0;
    end
    got = 0; hold = 0; prev = '0; cyc = 0;
    while (got < 8 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (hold) begin
        chk(out_valid === 1'b1, "R8", "valid held under stall", out_valid, 1);
        chk(out_data === prev, "R8", "data held under stall", out_data, prev);
      end
      chk(!(in_ready === 1'b1), "R3", "no input during pass compute/send", in_ready, 0);
      out_ready = (stall == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (out_valid) begin
        if (out_ready) begin
          chk($signed(out_data) == expv[got], req, $sformatf("pooled word %0d", got),
              $signed(out_data), expv[got]);
          got++;
        end
        hold = !out_ready;
        prev = out_data;
      end else hold = 0;
    end
    chk(got == 8, "R3", "output word count", got, 8);
    @(posedge clk); #1 out_ready = 1'b0;
    @(negedge clk);
    chk(done === 1'b1, "R9", "done after last output", done, 1);
    chk(out_valid === 1'b0, "R3", "no ninth output", out_valid, 0);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done lasts one cycle (pass)", done, 0);
  endtask

  task automatic set_pix(input int p);
    for (int i = 0; i < 64; i++)
      case (p)
        0: pix[i] = i - 32;
        1: pix[i] = ((i * 37) % 200) - 100;
        2: pix[i] = ((i % 2) != 0 ? -1 : 1) * (i * 500);
        default: pix[i] = 30000 - ((i * 911) % 60000);
      endcase
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_start = 0; cmd_op = 0; in_valid = 0; in_data = 0; out_ready = 0;
    for (int c = 0; c < 2; c++) begin
      bia[c] = 0;
      for (int k = 0; k < 25; k++) wgt[c][k] = 0;
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(in_ready === 1'b0, "R1", "in_ready after reset", in_ready, 0);
    chk(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(done === 1'b0, "R1", "done after reset", done, 0);

    issue(2'd0);
    issue(2'd3);
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      chk(in_ready === 1'b0 && out_valid === 1'b0, "R7", "reserved op ignored",
          {in_ready, out_valid}, 0);
    end

    set_pix(1);
    run_pass("R6", 0, 0);

    for (int c = 0; c < 2; c++) begin
      bia[c] = (c != 0) ? -100 : 50;
      for (int k = 0; k < 25; k++) wgt[c][k] = ((c * 7 + k * 3) % 11) - 5;
    end
    load_params();
    set_pix(0); run_pass("R4", 0, 0);
    set_pix(1); run_pass("R5", 1, 0);
    set_pix(2); run_pass("R7", 0, 1);
    set_pix(3); run_pass("R10", 1, 0);

    for (int c = 0; c < 2; c++) begin
      bia[c] = (c != 0) ? -20000 : 20000;
      for (int k = 0; k < 25; k++) wgt[c][k] = ((k * 1234 + c * 999) % 30000) - 15000;
    end
    load_params();
    set_pix(3); run_pass("R4", 1, 0);
    set_pix(2); run_pass("R2", 0, 0);
    set_pix(0); run_pass("R5", 1, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule